// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Read Path

This block is the read side of a small first-level cache. The cache set is chosen from the low bits of the virtual address, and these bits lie inside the page offset, so they are the same before and after translation. In the same cycle, a small fully associative translation buffer maps the virtual page number to a physical page number. The stored tags are physical, and they are compared with the translated page number plus any page-offset bits above the set index. Address translation therefore adds no cycle of its own before the cache can be indexed. Two virtual pages that alias one physical page always select the same set and the same line, so the cache never holds a duplicate copy of a line.

A requester presents a word-granular virtual address with a valid strobe. One cycle later the block returns a response valid flag, a hit flag, a translation-miss flag and the selected data word. The environment fills the translation buffer through its own port, and the buffer overwrites its slots in round-robin order. Cache lines arrive whole through a line fill port that is addressed by physical line address. Each set replaces its ways in round-robin order. The block has no page-table walk, no protection check and no write path.

Top module: `vipt_cache`

## Requirements
- R1: After a synchronous active-low reset, rsp_valid, rsp_hit and rsp_tlb_miss are 0, and every translation slot and every cache way is invalid, so any lookup reports a translation miss.
- R2: rsp_valid equals req_valid of the previous cycle. Each lookup takes exactly one cycle.
- R3: The set index is req_vaddr[LINE_OFF_W +: IDX_W], which lies inside the page offset. A line fill goes to the set given by the same bits of its physical line address (line_fill_laddr[IDX_W-1:0]).
- R4: The virtual page number is req_vaddr[VA_W-1:PAGE_OFF_W]. When no valid translation slot holds that page number, rsp_tlb_miss is 1 and rsp_hit is 0, whatever the cache holds.
- R5: A hit requires a translation hit and a valid way in the selected set whose stored tag equals {translated page number, req_vaddr[PAGE_OFF_W-1:LINE_OFF_W+IDX_W]}. On a hit, rsp_data is word req_vaddr[LINE_OFF_W-1:0] of that line, where word k is line_fill_data[k*DATA_W +: DATA_W].
- R6: Two virtual pages that translate to the same physical page, accessed with the same page offset, hit the same line and return the same word.
- R7: Translation fills occupy slots 0,1,...,TLB_ENTRIES-1 and then wrap. Fill number TLB_ENTRIES+1 evicts the first translation.
- R8: Within a set, line fills occupy ways in round-robin order. Fill number WAYS+1 to a set evicts the line that the first fill placed.
- R9: When a valid response is not a hit, rsp_data is 0. When rsp_valid is 0, rsp_hit and rsp_tlb_miss are both 0.
- R10: A lookup in the same cycle as a line fill to its set sees the contents from before the fill. The next lookup sees the new line.
- R11: Elaboration fails if IDX_W + LINE_OFF_W exceeds PAGE_OFF_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | VA_W | Virtual word address of the lookup |
| tlb_fill_en | input | 1 | Write one translation into the next round-robin slot |
| tlb_fill_vpn | input | VA_W-PAGE_OFF_W | Virtual page number of the translation |
| tlb_fill_ppn | input | PA_W-PAGE_OFF_W | Physical page number of the translation |
| line_fill_en | input | 1 | Write one cache line |
| line_fill_laddr | input | PA_W-log2(WORDS) | Physical line address: tag bits above the set index |
| line_fill_data | input | WORDS*DATA_W | Whole line, word 0 in the low bits |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Translation hit and physical tag match |
| rsp_tlb_miss | output | 1 | No translation for the virtual page |
| rsp_data | output | DATA_W | Selected word on a hit, else 0 |

## Verification
The hardest case to reach is an alias that outlives an eviction. A second virtual page must map onto a physical page that is already cached, while a later translation fill evicts the original mapping and a later line fill evicts one way of a set. Each of these events uses a different port. The bench steps through translation fills, line fills and further evictions in a fixed order, and it keeps a model of the slots and ways computed from the round-robin rules. After each phase it sweeps every virtual address and checks the whole address space against that model. It then drives a line fill and a lookup to the same set in one cycle to observe the pre-fill contents.

// File: rtl/vipt_pkg.sv
// Shared types for the virtually indexed, physically tagged read path.
package vipt_pkg;

    // Outcome of one lookup, registered into the response stage.
    typedef enum logic [1:0] {
        LK_IDLE       = 2'd0,
        LK_TLB_MISS   = 2'd1,
        LK_CACHE_MISS = 2'd2,
        LK_HIT        = 2'd3
    } lk_outcome_e;

endpackage

// File: rtl/vipt_tlb.sv
// Fully associative translation buffer.
// Does: combinational lookup of a virtual page number; a fill writes the
// next slot in round-robin order.
// Assumes: software never holds the same page number in two slots, so at
// most one slot matches and an AND-OR merge of the matches is exact.
module vipt_tlb #(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 4,
    parameter int PPN_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic [PTR_W-1:0]   ptr_q;
    logic [ENTRIES-1:0] match;

    // Valid bits and round-robin slot pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else if (fill_en) begin
            vld_q[ptr_q] <= 1'b1;
            ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // Translation payload of the slot being filled.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            vpn_q[ptr_q] <= fill_vpn;
            ppn_q[ptr_q] <= fill_ppn;
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match[e] = vld_q[e] && (vpn_q[e] == lk_vpn);
    end

    // Merge the matching slot's physical page number.
    always_comb begin
        lk_ppn = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (match[e]) lk_ppn = lk_ppn | ppn_q[e];
        end
        lk_hit = |match;
    end
endmodule

// File: rtl/vipt_tag_store.sv
// Set-associative tag, valid and line storage.
// Does: reads all ways of one set combinationally; a fill writes one line
// into the set's round-robin victim way.
// Assumes: the fill set index comes from the physical address and the
// lookup index from the virtual address, which agree inside a page.
module vipt_tag_store #(
    parameter int SETS   = 8,
    parameter int WAYS   = 2,
    parameter int TAG_W  = 5,
    parameter int LINE_W = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(SETS)-1:0]    lk_set,
    output logic [WAYS-1:0]            rd_vld,
    output logic [WAYS*TAG_W-1:0]      rd_tags,
    output logic [WAYS*LINE_W-1:0]     rd_lines,
    input  logic                       fill_en,
    input  logic [$clog2(SETS)-1:0]    fill_set,
    input  logic [TAG_W-1:0]           fill_tag,
    input  logic [LINE_W-1:0]          fill_line
);
    localparam int VW = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [TAG_W-1:0]  tag_q    [SETS][WAYS];
    logic [LINE_W-1:0] line_q   [SETS][WAYS];
    logic [WAYS-1:0]   vld_q    [SETS];
    logic [VW-1:0]     victim_q [SETS];

    // Valid bits and per-set replacement pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s]    <= '0;
                victim_q[s] <= '0;
            end
        end else if (fill_en) begin
            vld_q[fill_set][victim_q[fill_set]] <= 1'b1;
            victim_q[fill_set] <= (victim_q[fill_set] == VW'(WAYS - 1)) ?
                                  '0 : victim_q[fill_set] + 1'b1;
        end
    end

    // Tag and line payload of the victim way.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_set][victim_q[fill_set]]  <= fill_tag;
            line_q[fill_set][victim_q[fill_set]] <= fill_line;
        end
    end

    // Present every way of the indexed set.
    always_comb begin
        rd_vld = vld_q[lk_set];
        for (int w = 0; w < WAYS; w++) begin
            rd_tags[w*TAG_W +: TAG_W]    = tag_q[lk_set][w];
            rd_lines[w*LINE_W +: LINE_W] = line_q[lk_set][w];
        end
    end
endmodule

// File: rtl/vipt_way_match.sv
// Physical tag comparison across the ways of one set.
// Does: flags a hit only if translation succeeded and a valid way holds
// the compare tag, and returns that way's line.
// Assumes: at most one way of a set holds a given tag.
module vipt_way_match #(
    parameter int WAYS   = 2,
    parameter int TAG_W  = 5,
    parameter int LINE_W = 64
) (
    input  logic                   tlb_hit,
    input  logic [TAG_W-1:0]       cmp_tag,
    input  logic [WAYS-1:0]        way_vld,
    input  logic [WAYS*TAG_W-1:0]  way_tags,
    input  logic [WAYS*LINE_W-1:0] way_lines,
    output logic                   hit,
    output logic [LINE_W-1:0]      line
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match[w] = way_vld[w] && (way_tags[w*TAG_W +: TAG_W] == cmp_tag);
    end

    // Merge the matching way's line and qualify with translation.
    always_comb begin
        line = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) line = line | way_lines[w*LINE_W +: LINE_W];
        end
        hit = tlb_hit && (|match);
    end
endmodule

// File: rtl/vipt_cache.sv
// Top of the virtually indexed, physically tagged L1 read path.
// Does: indexes the set with page-offset bits of the virtual address while
// the translation buffer maps the page number in the same cycle; compares
// the physical tag and registers a one-cycle response.
// Assumes: word-granular addresses, WORDS and SETS powers of two, WORDS >= 2.
module vipt_cache
    import vipt_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int WORDS       = 4,
    parameter int SETS        = 8,
    parameter int WAYS        = 2,
    parameter int PAGE_OFF_W  = 6,
    parameter int VA_W        = 10,
    parameter int PA_W        = 10,
    parameter int TLB_ENTRIES = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    input  logic [VA_W-1:0]                     req_vaddr,
    input  logic                                tlb_fill_en,
    input  logic [VA_W-PAGE_OFF_W-1:0]          tlb_fill_vpn,
    input  logic [PA_W-PAGE_OFF_W-1:0]          tlb_fill_ppn,
    input  logic                                line_fill_en,
    input  logic [PA_W-$clog2(WORDS)-1:0]       line_fill_laddr,
    input  logic [WORDS*DATA_W-1:0]             line_fill_data,
    output logic                                rsp_valid,
    output logic                                rsp_hit,
    output logic                                rsp_tlb_miss,
    output logic [DATA_W-1:0]                   rsp_data
);
    localparam int LINE_OFF_W = $clog2(WORDS);
    localparam int IDX_W      = $clog2(SETS);
    localparam int VPN_W      = VA_W - PAGE_OFF_W;
    localparam int PPN_W      = PA_W - PAGE_OFF_W;
    localparam int SPARE_W    = PAGE_OFF_W - IDX_W - LINE_OFF_W;
    localparam int TAG_W      = PPN_W + SPARE_W;
    localparam int LINE_W     = WORDS * DATA_W;

    logic                  tlb_hit;
    logic [PPN_W-1:0]      tlb_ppn;
    logic [TAG_W-1:0]      cmp_tag;
    logic [WAYS-1:0]       way_vld;
    logic [WAYS*TAG_W-1:0] way_tags;
    logic [WAYS*LINE_W-1:0] way_lines;
    logic                  way_hit;
    logic [LINE_W-1:0]     hit_line;
    logic [LINE_OFF_W-1:0] word_sel;
    lk_outcome_e           out_d, out_q;
    logic [DATA_W-1:0]     data_d, data_q;

    // R11: the set index and word offset must fit inside the page offset.
    if (SPARE_W < 0) begin : g_bad_geometry
        $error("vipt_cache: set index and line offset exceed the page offset");
    end else if (SPARE_W > 0) begin : g_spare
        assign cmp_tag = {tlb_ppn, req_vaddr[PAGE_OFF_W-1 -: SPARE_W]};
    end else begin : g_no_spare
        assign cmp_tag = tlb_ppn;
    end

    assign word_sel = req_vaddr[LINE_OFF_W-1:0];

    vipt_tlb #(
        .ENTRIES (TLB_ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W)
    ) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (req_vaddr[VA_W-1 -: VPN_W]),
        .lk_hit   (tlb_hit),
        .lk_ppn   (tlb_ppn),
        .fill_en  (tlb_fill_en),
        .fill_vpn (tlb_fill_vpn),
        .fill_ppn (tlb_fill_ppn)
    );

    vipt_tag_store #(
        .SETS   (SETS),
        .WAYS   (WAYS),
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_set    (req_vaddr[LINE_OFF_W +: IDX_W]),
        .rd_vld    (way_vld),
        .rd_tags   (way_tags),
        .rd_lines  (way_lines),
        .fill_en   (line_fill_en),
        .fill_set  (line_fill_laddr[IDX_W-1:0]),
        .fill_tag  (line_fill_laddr[IDX_W +: TAG_W]),
        .fill_line (line_fill_data)
    );

    vipt_way_match #(
        .WAYS   (WAYS),
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W)
    ) u_match (
        .tlb_hit   (tlb_hit),
        .cmp_tag   (cmp_tag),
        .way_vld   (way_vld),
        .way_tags  (way_tags),
        .way_lines (way_lines),
        .hit       (way_hit),
        .line      (hit_line)
    );

    // Classify the lookup and pick the returned word.
    always_comb begin
        data_d = '0;
        if (!req_valid)    out_d = LK_IDLE;
        else if (!tlb_hit) out_d = LK_TLB_MISS;
        else if (way_hit)  out_d = LK_HIT;
        else               out_d = LK_CACHE_MISS;
        if (out_d == LK_HIT) data_d = hit_line[word_sel*DATA_W +: DATA_W];
    end

    // Response register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= LK_IDLE;
            data_q <= '0;
        end else begin
            out_q  <= out_d;
            data_q <= data_d;
        end
    end

    assign rsp_valid    = (out_q != LK_IDLE);
    assign rsp_hit      = (out_q == LK_HIT);
    assign rsp_tlb_miss = (out_q == LK_TLB_MISS);
    assign rsp_data     = data_q;
endmodule

// File: rtl/vipt_cache_chk.sv
// Protocol checker for vipt_cache, attached by bind.
// Does: relates requests, the internal translation result and the
// registered response flags over time.
// Assumes: synchronous active-low reset.
module vipt_cache_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              tlb_hit,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_tlb_miss,
    input logic [DATA_W-1:0] rsp_data
);
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_hit_excludes_tlb_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> !rsp_tlb_miss);

    assert_hit_needs_translation_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !tlb_hit) |=> (!rsp_hit && rsp_tlb_miss));

    assert_miss_data_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_data == '0));

    assert_idle_flags_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_tlb_miss));
endmodule

bind vipt_cache vipt_cache_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .tlb_hit      (tlb_hit),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_tlb_miss (rsp_tlb_miss),
    .rsp_data     (rsp_data)
);

// File: tb/vipt_cache_tb_top.sv
// Self-checking bench for vipt_cache at its default geometry: 16-bit words,
// 4 words per line, 8 sets, 2 ways, 64-word pages, 10-bit addresses and
// 4 translation slots. Sweeps all 1024 virtual addresses after each phase
// against a model derived from the round-robin and tag rules.
module vipt_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [9:0]  req_vaddr = '0;
    logic        tlb_fill_en = 1'b0;
    logic [3:0]  tlb_fill_vpn = '0;
    logic [3:0]  tlb_fill_ppn = '0;
    logic        line_fill_en = 1'b0;
    logic [7:0]  line_fill_laddr = '0;
    logic [63:0] line_fill_data = '0;
    logic        rsp_valid, rsp_hit, rsp_tlb_miss;
    logic [15:0] rsp_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Model state built from the requirements.
    int tlb_vpn [4];
    int tlb_ppn [4];
    bit tlb_v   [4];
    int tlb_ptr = 0;
    int c_tag   [8][2];
    bit c_v     [8][2];
    int c_ptr   [8];

    always #5 clk = ~clk;

    vipt_cache dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_vaddr       (req_vaddr),
        .tlb_fill_en     (tlb_fill_en),
        .tlb_fill_vpn    (tlb_fill_vpn),
        .tlb_fill_ppn    (tlb_fill_ppn),
        .line_fill_en    (line_fill_en),
        .line_fill_laddr (line_fill_laddr),
        .line_fill_data  (line_fill_data),
        .rsp_valid       (rsp_valid),
        .rsp_hit         (rsp_hit),
        .rsp_tlb_miss    (rsp_tlb_miss),
        .rsp_data        (rsp_data)
    );

    function automatic logic [15:0] dval(int tag, int set, int w);
        return 16'(32'h8000 | (tag << 8) | (set << 4) | w);
    endfunction

    function automatic int mk_va(int vpn, int spare, int set, int w);
        return (vpn << 6) | (spare << 5) | (set << 2) | w;
    endfunction

    task automatic check(string req, bit ok, string act, string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    // One lookup: expectation taken from the model before the clock edge.
    task automatic lookup(int va, string req);
        bit e_tm = 1'b1, e_hit = 1'b0;
        logic [15:0] e_data = '0;
        int vpn = va >> 6, spare = (va >> 5) & 1, set = (va >> 2) & 7, w = va & 3;
        for (int i = 0; i < 4; i++) begin
            if (tlb_v[i] && tlb_vpn[i] == vpn) begin
                e_tm = 1'b0;
                for (int k = 0; k < 2; k++)
                    if (c_v[set][k] && c_tag[set][k] == tlb_ppn[i] * 2 + spare) begin
                        e_hit  = 1'b1;
                        e_data = dval(c_tag[set][k], set, w);
                    end
            end
        end
        req_valid = 1'b1;
        req_vaddr = 10'(va);
        @(negedge clk);
        req_valid = 1'b0;
        check(req, rsp_valid === 1'b1 && rsp_hit === e_hit &&
                   rsp_tlb_miss === e_tm && rsp_data === e_data,
              $sformatf("va=%0h v%0b h%0b tm%0b d%h", va, rsp_valid, rsp_hit, rsp_tlb_miss, rsp_data),
              $sformatf("v1 h%0b tm%0b d%h", e_hit, e_tm, e_data));
    endtask

    task automatic sweep();
        for (int va = 0; va < 1024; va++) begin
            lookup(va, "R3/R4/R5/R9 sweep");
        end
    endtask

    task automatic tlb_fill(int vpn, int ppn);
        tlb_fill_en = 1'b1;
        tlb_fill_vpn = 4'(vpn);
        tlb_fill_ppn = 4'(ppn);
        @(negedge clk);
        tlb_fill_en = 1'b0;
        tlb_vpn[tlb_ptr] = vpn;
        tlb_ppn[tlb_ptr] = ppn;
        tlb_v[tlb_ptr]   = 1'b1;
        tlb_ptr = (tlb_ptr + 1) % 4;
    endtask

    task automatic line_drive(int tag, int set);
        line_fill_en = 1'b1;
        line_fill_laddr = 8'((tag << 3) | set);
        for (int w = 0; w < 4; w++) line_fill_data[w*16 +: 16] = dval(tag, set, w);
    endtask

    task automatic line_model(int tag, int set);
        line_fill_en = 1'b0;
        c_tag[set][c_ptr[set]] = tag;
        c_v[set][c_ptr[set]]   = 1'b1;
        c_ptr[set] = (c_ptr[set] + 1) % 2;
    endtask

    task automatic line_fill(int tag, int set);
        line_drive(tag, set);
        @(negedge clk);
        line_model(tag, set);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) tlb_v[i] = 1'b0;
        for (int s = 0; s < 8; s++) begin
            c_ptr[s] = 0;
            for (int k = 0; k < 2; k++) c_v[s][k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: response flags low after reset; first sweep proves everything invalid.
        check("R1", rsp_valid === 1'b0 && rsp_hit === 1'b0 && rsp_tlb_miss === 1'b0,
              $sformatf("%0b%0b%0b", rsp_valid, rsp_hit, rsp_tlb_miss), "000");
        sweep();

        // R7: four translations fill slots 0..3; no lines yet, so R9 misses.
        tlb_fill(0, 3);
        tlb_fill(1, 8);
        tlb_fill(2, 13);
        tlb_fill(3, 2);
        sweep();

        // R3/R8: two lines per set, tags {ppn3,spare0} and {ppn8,spare1}.
        for (int s = 0; s < 8; s++) begin
            line_fill(3 * 2 + 0, s);
            line_fill(8 * 2 + 1, s);
        end
        sweep();

        // R7: fifth fill wraps to slot 0 and evicts page 0; page 9 aliases page 1.
        tlb_fill(9, 8);
        lookup(mk_va(0, 0, 2, 1), "R7 evicted translation");
        check("R7", rsp_tlb_miss === 1'b1, $sformatf("%0b", rsp_tlb_miss), "1");
        // R6: synonyms hit the same line and return the same word.
        lookup(mk_va(1, 1, 3, 2), "R6 first alias");
        check("R6", rsp_hit === 1'b1 && rsp_data === dval(17, 3, 2),
              $sformatf("%0b %h", rsp_hit, rsp_data), $sformatf("1 %h", dval(17, 3, 2)));
        lookup(mk_va(9, 1, 3, 2), "R6 second alias");
        check("R6", rsp_hit === 1'b1 && rsp_data === dval(17, 3, 2),
              $sformatf("%0b %h", rsp_hit, rsp_data), $sformatf("1 %h", dval(17, 3, 2)));
        sweep();

        // R8: third tag in set 5 evicts the first-placed way (ppn3).
        line_fill(13 * 2, 5);
        tlb_fill(12, 3);
        lookup(mk_va(12, 0, 5, 0), "R8 evicted way");
        check("R8", rsp_hit === 1'b0 && rsp_tlb_miss === 1'b0,
              $sformatf("%0b%0b", rsp_hit, rsp_tlb_miss), "00");
        lookup(mk_va(12, 0, 4, 0), "R8 other set kept");
        lookup(mk_va(2, 0, 5, 3), "R8 new line");
        check("R8", rsp_hit === 1'b1, $sformatf("%0b", rsp_hit), "1");
        sweep();

        // R10: fill and lookup to set 6 in one cycle see the old contents.
        line_drive(13 * 2, 6);
        lookup(mk_va(12, 0, 6, 1), "R10 old line still seen");
        line_model(13 * 2, 6);
        lookup(mk_va(12, 0, 6, 1), "R10 old line gone");
        check("R10", rsp_hit === 1'b0, $sformatf("%0b", rsp_hit), "0");
        lookup(mk_va(2, 0, 6, 1), "R10 new line visible");
        check("R10", rsp_hit === 1'b1, $sformatf("%0b", rsp_hit), "1");
        sweep();

        // R2/R9: no request gives no response and no flags.
        req_vaddr = 10'(mk_va(2, 0, 6, 1));
        @(negedge clk);
        check("R2", rsp_valid === 1'b0 && rsp_hit === 1'b0 && rsp_tlb_miss === 1'b0,
              $sformatf("%0b%0b%0b", rsp_valid, rsp_hit, rsp_tlb_miss), "000");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule